// File: doc/BRIEF.md
# Raster Pixel Port Transmitter

This block turns a frame-buffer pixel stream into a parallel digital video port. A raster generator walks each line through four regions: active pixels, front porch, sync and back porch. Lines are grouped the same way into fields, and fields into frames. One pixel is taken per pixel clock, left to right and top to bottom. It leaves on three 12-bit colour buses, together with active-video, composite-sync, vertical-sync and field indicators. Every output comes from a register clocked on the rising pixel-clock edge.

The active-video indicator always runs exactly three clocks ahead of the pixel it announces, so a receiver has time to prepare. A rate-band setting inserts 0, 2 or 3 extra clocks into the pipeline to suit fast pixel clocks. The extra delay moves the indicators and the data together, so the three-clock lead is kept. In place of the pixel clock the port emits two half-rate clocks, one a quarter period behind the other.

A luminance mode spreads a 16-bit value across all three buses. A power-good input forces every output low while the attached receiver is unpowered. The timing lengths, interlace, rate band and luminance mode are sampled only at the start of a frame.

Top module: `raster_port_tx`

## Requirements
- R1: `pix_ready` is high exactly during the raster positions with column below the active width and line below the active height. A pixel is consumed in each cycle where `pix_ready` and `pix_valid` are both high.
- R2: In colour mode, `pix_data` bits 35:24 leave on red, 23:12 on green and 11:0 on blue. With rate band 0, a pixel consumed in cycle t appears in cycle t+4.
- R3: With rate band 0, `vid_active` goes high in cycle t+1 for a raster position in cycle t. This is three cycles before that position's pixel.
- R4: Rate band code 0 adds no delay, code 1 adds 2 clocks and codes 2 and 3 add 3 clocks. The added delay applies equally to the indicators and the data.
- R5: Within a line, columns from active+front to active+front+sync-1 are the horizontal sync. Lines from active+front to active+front+sync-1 are the vertical sync. `vid_vsync` is high on vertical-sync lines, and `vid_csync` is the OR of the horizontal and vertical sync.
- R6: `vid_field` stays low when interlace is off. When interlace is on, every second field of a frame has `vid_field` high on all of its positions.
- R7: In luminance mode, with L = `pix_data`[15:0], red and green both carry L[15:4] and blue carries {L[15:8], L[3:0]}.
- R8: `clk_half_i` toggles on every rising edge while power is good. `clk_half_q` copies `clk_half_i` on each falling edge, so it lags by a quarter of its period.
- R9: `rsv_sel` is always 2'b00.
- R10: During reset, and in any cycle after a rising edge at which `pwr_good` was low, all colour, indicator and clock outputs are low.
- R11: Every timing length, the interlace flag, the rate band and the luminance mode are sampled only at the start of a frame and just after reset. A change made in mid-frame has no effect until the next frame.
- R12: An active position where `pix_valid` is low produces an all-zero pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Receiver powered; low forces outputs low |
| cfg_h_act | input | 12 | Active pixels per line |
| cfg_h_front | input | 12 | Horizontal front porch length |
| cfg_h_sync | input | 12 | Horizontal sync length |
| cfg_h_back | input | 12 | Horizontal back porch length |
| cfg_v_act | input | 11 | Active lines per field |
| cfg_v_front | input | 11 | Vertical front porch lines |
| cfg_v_sync | input | 11 | Vertical sync lines |
| cfg_v_back | input | 11 | Vertical back porch lines |
| cfg_interlace | input | 1 | Two fields per frame when high |
| cfg_rate_band | input | 2 | Extra pipeline delay select (R4) |
| cfg_luma | input | 1 | 16-bit luminance packing |
| pix_valid | input | 1 | Source has a pixel |
| pix_data | input | 36 | Pixel: red, green, blue from the top; luminance in bits 15:0 |
| pix_ready | output | 1 | Pixel consumed this cycle when valid |
| vid_red | output | 12 | Red bus |
| vid_green | output | 12 | Green bus |
| vid_blue | output | 12 | Blue bus |
| vid_active | output | 1 | Active video, three clocks ahead of data |
| vid_csync | output | 1 | Composite sync, active high |
| vid_vsync | output | 1 | Vertical sync, active high |
| vid_field | output | 1 | High during the second field |
| clk_half_i | output | 1 | Half-rate clock, in phase |
| clk_half_q | output | 1 | Half-rate clock, quadrature |
| rsv_sel | output | 2 | Reserved selects, held low |

## Verification
A raster counter that slips or wraps at the wrong column shows up straight away at `pix_ready`. It shows on `vid_active` or the syncs one to four clocks later, depending on the band. A pipeline tap picked for the wrong band breaks the three-clock lead of `vid_active` over the pixel data at the first active edge. A config shadow that loads in mid-frame changes the `pix_ready` pattern on the next line instead of the next frame. A field flag that toggles at the wrong time is visible on `vid_field` within one field.

// File: rtl/raster_port_tx.sv
module raster_port_tx #(
  parameter int CW = 12,
  parameter int HW = 12,
  parameter int VW = 11,
  parameter int LW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwr_good,
  input  logic [HW-1:0]   cfg_h_act,
  input  logic [HW-1:0]   cfg_h_front,
  input  logic [HW-1:0]   cfg_h_sync,
  input  logic [HW-1:0]   cfg_h_back,
  input  logic [VW-1:0]   cfg_v_act,
  input  logic [VW-1:0]   cfg_v_front,
  input  logic [VW-1:0]   cfg_v_sync,
  input  logic [VW-1:0]   cfg_v_back,
  input  logic            cfg_interlace,
  input  logic [1:0]      cfg_rate_band,
  input  logic            cfg_luma,
  input  logic            pix_valid,
  input  logic [3*CW-1:0] pix_data,
  output logic            pix_ready,
  output logic [CW-1:0]   vid_red,
  output logic [CW-1:0]   vid_green,
  output logic [CW-1:0]   vid_blue,
  output logic            vid_active,
  output logic            vid_csync,
  output logic            vid_vsync,
  output logic            vid_field,
  output logic            clk_half_i,
  output logic            clk_half_q,
  output logic [1:0]      rsv_sel
);
  localparam int PW = 3 * CW;
  localparam int LO = LW - CW;
  localparam int HT = HW + 2;
  localparam int VT = VW + 2;
  localparam int AD = 3;
  localparam int DD = 6;

  logic          run, field_q;
  logic [HT-1:0] h_cnt;
  logic [VT-1:0] v_cnt;
  logic [HW-1:0] s_ha, s_hf, s_hs, s_hb;
  logic [VW-1:0] s_va, s_vf, s_vs, s_vb;
  logic          s_il, s_luma;
  logic [1:0]    s_band;

  logic [HT-1:0] h_sb, h_se, h_last;
  logic [VT-1:0] v_sb, v_se, v_last;
  assign h_sb   = HT'(s_ha) + HT'(s_hf);
  assign h_se   = h_sb + HT'(s_hs);
  assign h_last = h_se + HT'(s_hb) - HT'(1);
  assign v_sb   = VT'(s_va) + VT'(s_vf);
  assign v_se   = v_sb + VT'(s_vs);
  assign v_last = v_se + VT'(s_vb) - VT'(1);

  logic line_end, field_end, next_field, load;
  assign line_end   = h_cnt == h_last;
  assign field_end  = line_end && (v_cnt == v_last);
  assign next_field = s_il & ~field_q;
  assign load       = !run || (field_end && !next_field);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; field_q <= 1'b0; h_cnt <= '0; v_cnt <= '0;
      s_ha <= '0; s_hf <= '0; s_hs <= '0; s_hb <= '0;
      s_va <= '0; s_vf <= '0; s_vs <= '0; s_vb <= '0;
      s_il <= 1'b0; s_luma <= 1'b0; s_band <= 2'b00;
    end else begin
      run <= 1'b1;
      if (load) begin
        s_ha <= cfg_h_act; s_hf <= cfg_h_front; s_hs <= cfg_h_sync; s_hb <= cfg_h_back;
        s_va <= cfg_v_act; s_vf <= cfg_v_front; s_vs <= cfg_v_sync; s_vb <= cfg_v_back;
        s_il <= cfg_interlace; s_luma <= cfg_luma; s_band <= cfg_rate_band;
      end
      if (!run) begin
        h_cnt <= '0; v_cnt <= '0; field_q <= 1'b0;
      end else if (line_end) begin
        h_cnt <= '0;
        if (field_end) begin
          v_cnt   <= '0;
          field_q <= next_field;
        end else begin
          v_cnt <= v_cnt + VT'(1);
        end
      end else begin
        h_cnt <= h_cnt + HT'(1);
      end
    end
  end

  logic act_raw, hs_raw, vs_raw;
  assign act_raw = run && (h_cnt < HT'(s_ha)) && (v_cnt < VT'(s_va));
  assign hs_raw  = run && (h_cnt >= h_sb) && (h_cnt < h_se);
  assign vs_raw  = run && (v_cnt >= v_sb) && (v_cnt < v_se);
  assign pix_ready = act_raw;

  logic [3:0]    ctrl_raw;
  logic [PW-1:0] packed_px;
  logic [LW-1:0] lum;
  assign ctrl_raw = {act_raw, hs_raw | vs_raw, vs_raw, run & field_q};
  assign lum      = pix_data[LW-1:0];
  assign packed_px = !(act_raw && pix_valid) ? '0 :
                     s_luma ? {lum[LW-1 -: CW], lum[LW-1 -: CW], lum[LW-1 -: CW-LO], lum[LO-1:0]} :
                     pix_data;

  logic [3:0]    a_pipe [AD];
  logic [PW-1:0] d_pipe [DD];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < AD; i++) a_pipe[i] <= '0;
      for (int i = 0; i < DD; i++) d_pipe[i] <= '0;
    end else begin
      a_pipe[0] <= ctrl_raw;
      for (int i = 1; i < AD; i++) a_pipe[i] <= a_pipe[i-1];
      d_pipe[0] <= packed_px;
      for (int i = 1; i < DD; i++) d_pipe[i] <= d_pipe[i-1];
    end
  end

  logic [3:0]    ctrl_tap;
  logic [PW-1:0] data_tap;
  always_comb begin
    case (s_band)
      2'b00:   begin ctrl_tap = ctrl_raw;  data_tap = d_pipe[2]; end
      2'b01:   begin ctrl_tap = a_pipe[1]; data_tap = d_pipe[4]; end
      default: begin ctrl_tap = a_pipe[2]; data_tap = d_pipe[5]; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {vid_active, vid_csync, vid_vsync, vid_field} <= '0;
      {vid_red, vid_green, vid_blue} <= '0;
      clk_half_i <= 1'b0;
    end else if (!pwr_good) begin
      {vid_active, vid_csync, vid_vsync, vid_field} <= '0;
      {vid_red, vid_green, vid_blue} <= '0;
      clk_half_i <= 1'b0;
    end else begin
      {vid_active, vid_csync, vid_vsync, vid_field} <= ctrl_tap;
      {vid_red, vid_green, vid_blue} <= data_tap;
      clk_half_i <= ~clk_half_i;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) clk_half_q <= 1'b0;
    else        clk_half_q <= clk_half_i;
  end

  assign rsv_sel = 2'b00;
endmodule

// File: rtl/raster_port_tx_chk.sv
module raster_port_tx_chk #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pwr_good,
  input logic          pix_ready,
  input logic [CW-1:0] vid_red,
  input logic [CW-1:0] vid_green,
  input logic [CW-1:0] vid_blue,
  input logic          vid_active,
  input logic          vid_csync,
  input logic          vid_vsync,
  input logic          clk_half_i,
  input logic          clk_half_q,
  input logic [1:0]    rsv_sel,
  input logic [1:0]    band
);
  logic [2:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= '0;
    else if (age != 3'd7) age <= age + 3'd1;
  end
  logic armed;
  assign armed = age == 3'd7;

  always_comb AST_RSV_LOW: assert (!rst_n || rsv_sel == 2'b00); // R9

  AST_PG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(pwr_good)) |-> (!vid_active && !vid_csync && !clk_half_i &&
      vid_red == '0 && vid_green == '0 && vid_blue == '0)); // R10

  AST_CLK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(pwr_good)) |-> (clk_half_i != $past(clk_half_i))); // R8

  AST_CLK_QUAD: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (clk_half_q == clk_half_i)); // R8

  AST_LEAD_BAND0: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(pwr_good) && $past(band) == 2'b00) |-> (vid_active == $past(pix_ready))); // R3

  AST_LEAD_BAND1: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(pwr_good) && $past(band) == 2'b01) |-> (vid_active == $past(pix_ready, 3))); // R4

  AST_LEAD_BAND2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(pwr_good) && $past(band[1])) |-> (vid_active == $past(pix_ready, 4))); // R4

  AST_VSYNC_IN_CSYNC: assert property (@(posedge clk) disable iff (!rst_n)
    vid_vsync |-> vid_csync); // R5
endmodule

bind raster_port_tx raster_port_tx_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .pix_ready(pix_ready),
  .vid_red(vid_red), .vid_green(vid_green), .vid_blue(vid_blue),
  .vid_active(vid_active), .vid_csync(vid_csync), .vid_vsync(vid_vsync),
  .clk_half_i(clk_half_i), .clk_half_q(clk_half_q), .rsv_sel(rsv_sel), .band(s_band)
);

// File: tb/raster_port_tx_bench.sv
module raster_port_tx_bench;
  localparam int CW = 12, HW = 12, VW = 11, LW = 16, PW = 36;

  logic clk = 1'b0, rst_n = 1'b0, pwr_good = 1'b1;
  logic [HW-1:0] cfg_h_act = 8, cfg_h_front = 2, cfg_h_sync = 3, cfg_h_back = 2;
  logic [VW-1:0] cfg_v_act = 4, cfg_v_front = 1, cfg_v_sync = 2, cfg_v_back = 1;
  logic cfg_interlace = 1'b0, cfg_luma = 1'b0;
  logic [1:0] cfg_rate_band = 2'b00;
  logic pix_valid = 1'b0;
  logic [PW-1:0] pix_data = '0;
  logic pix_ready, vid_active, vid_csync, vid_vsync, vid_field, clk_half_i, clk_half_q;
  logic [CW-1:0] vid_red, vid_green, vid_blue;
  logic [1:0] rsv_sel;

  raster_port_tx #(.CW(CW), .HW(HW), .VW(VW), .LW(LW)) u_raster_port_tx (.*);

  always #2 clk = ~clk;

  int vectors = 0, errors = 0, t = 15, vpct = 90;
  string tag_rdy = "R1", tag_dat = "R2";

  int m_h = 0, m_v = 0, m_f = 0;
  int m_ha, m_hf, m_hs, m_hb, m_va, m_vf, m_vs, m_vb, m_il, m_luma, m_band;
  logic [3:0]    hc [16];
  logic [PW-1:0] hd [16];
  int            hb [16];
  logic pg_prev = 1'b1, exp_ci = 1'b0;

  task automatic chk(string req, string what, logic [63:0] got, logic [63:0] exp);
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0d)", req, what, got, exp, t);
    end
  endtask

  function automatic int bdelay(int b);
    return (b == 0) ? 0 : (b == 1) ? 2 : 3;
  endfunction

  function automatic logic [PW-1:0] pack(logic [PW-1:0] d, int luma);
    logic [15:0] l = d[15:0];
    return luma ? {l[15:4], l[15:4], l[15:8], l[3:0]} : d;
  endfunction

  task automatic load_shadow();
    m_ha = cfg_h_act; m_hf = cfg_h_front; m_hs = cfg_h_sync; m_hb = cfg_h_back;
    m_va = cfg_v_act; m_vf = cfg_v_front; m_vs = cfg_v_sync; m_vb = cfg_v_back;
    m_il = cfg_interlace; m_luma = cfg_luma; m_band = cfg_rate_band;
  endtask

  task automatic step(logic pg_next);
    int hsb, hse, hl, vsb, vse, vl, b;
    logic ract, rhs, rvs;
    logic [3:0] ec;
    logic [PW-1:0] ed;
    @(negedge clk); #1;
    t++; vectors++;
    hsb = m_ha + m_hf; hse = hsb + m_hs; hl = hse + m_hb - 1;
    vsb = m_va + m_vf; vse = vsb + m_vs; vl = vse + m_vb - 1;
    ract = (m_h < m_ha) && (m_v < m_va);
    rhs = (m_h >= hsb) && (m_h < hse);
    rvs = (m_v >= vsb) && (m_v < vse);
    b  = bdelay(hb[(t-1)%16]);
    ec = pg_prev ? hc[(t-1-b)%16] : 4'h0;
    ed = pg_prev ? hd[(t-4-b)%16] : '0;
    exp_ci = pg_prev ? ~exp_ci : 1'b0;
    chk(tag_rdy, "pix_ready", 64'(pix_ready), 64'(ract));
    chk(!pg_prev ? "R10" : (b != 0 ? "R4" : "R3"), "vid_active", 64'(vid_active), 64'(ec[3]));
    chk(!pg_prev ? "R10" : "R5", "vid_csync", 64'(vid_csync), 64'(ec[2]));
    chk(!pg_prev ? "R10" : "R5", "vid_vsync", 64'(vid_vsync), 64'(ec[1]));
    chk(!pg_prev ? "R10" : "R6", "vid_field", 64'(vid_field), 64'(ec[0]));
    chk(!pg_prev ? "R10" : tag_dat, "rgb", 64'({vid_red, vid_green, vid_blue}), 64'(ed));
    chk(!pg_prev ? "R10" : "R8", "clk_half_i", 64'(clk_half_i), 64'(exp_ci));
    chk("R8", "clk_half_q", 64'(clk_half_q), 64'(clk_half_i));
    chk("R9", "rsv_sel", 64'(rsv_sel), 64'(0));
    pix_valid = ($urandom_range(99) < vpct);
    pix_data  = PW'({$urandom(), $urandom()});
    pwr_good  = pg_next;
    hc[t%16] = {ract, rhs | rvs, rvs, m_f[0]};
    hd[t%16] = (ract && pix_valid) ? pack(pix_data, m_luma) : '0;
    hb[t%16] = m_band;
    pg_prev = pwr_good;
    if (m_h == hl) begin
      m_h = 0;
      if (m_v == vl) begin
        m_v = 0;
        m_f = m_il ? 1 - m_f : 0;
        if (m_f == 0) load_shadow();
      end else m_v++;
    end else m_h++;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step(1'b1);
  endtask

  initial begin
    void'($urandom(32'h5eed_0017));
    for (int i = 0; i < 16; i++) begin hc[i] = '0; hd[i] = '0; hb[i] = 0; end
    load_shadow();
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    vectors++;
    chk("R10", "reset outputs", 64'({vid_active, vid_csync, vid_vsync, vid_field, clk_half_i, clk_half_q, pix_ready}), 64'(0));
    chk("R10", "reset rgb", 64'({vid_red, vid_green, vid_blue}), 64'(0));
    rst_n = 1'b1;
    run(250);                                    // R2 R3 R5 colour, band 0
    cfg_rate_band = 2'b01; run(300);             // R4 applied at frame start
    cfg_h_act = 6; cfg_v_sync = 1; cfg_v_back = 2; tag_rdy = "R11";
    run(300);                                    // R11 mid-frame change
    tag_rdy = "R1";
    cfg_interlace = 1'b1; cfg_rate_band = 2'b10; run(600); // R6
    cfg_luma = 1'b1; cfg_rate_band = 2'b11; tag_dat = "R7"; run(300);
    vpct = 0; tag_dat = "R12"; cfg_luma = 1'b0; run(250);
    vpct = 90; tag_dat = "R2"; cfg_interlace = 1'b0; cfg_rate_band = 2'b00; run(150);
    for (int i = 0; i < 40; i++) step(1'b0);     // R10 power-good low
    run(200);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule